// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is a single timer channel. A down counter ticks at the clock rate divided by 1, 16 or 256. On the tick where the count is already zero, the channel raises a sticky interrupt and then takes one of three actions. In free-running mode it wraps to all ones. In periodic mode it reloads the programmed start value. In one-shot mode it stops. The counter is 32 bits wide or, in narrow mode, only its low 16 bits count. Two instances on one clock make a dual timer.

Software writes a start value to one of two registers. The direct load register arms a pending load that replaces the count on the next tick. The deferred load register changes only the value used at the next reload. A control register holds enable, width, prescale, mode and interrupt-enable bits. The raw and masked interrupt flags can be read, and any write to the clear register drops the raw flag. Reads are combinational from the address.

The control is a small state machine with three states:
- `ST_IDLE`: enable is clear.
- `ST_RUN`: enable is set and counting is allowed.
- `ST_STOP`: a one-shot run has expired.

Its transitions are:
- IDLE→RUN: enable is set.
- RUN→IDLE: enable is cleared.
- RUN→STOP: a one-shot expiry.
- STOP→RUN: a direct load write while enable is set.
- STOP→IDLE: a direct load write while enable is clear.

Top module: `timer_channel`

Register word offsets (byte address):

| Offset | Access | Contents |
|---|---|---|
| 0x00 | read/write | direct load |
| 0x04 | read-only | current count |
| 0x08 | read/write | control |
| 0x0C | write-only | interrupt clear |
| 0x10 | read-only | raw flag in bit 0 |
| 0x14 | read-only | masked flag in bit 0 |
| 0x18 | write | deferred load; reads return the load value |

Control bits:

| Bit | Meaning |
|---|---|
| [7] | enable |
| [6] | periodic |
| [5] | interrupt enable |
| [4] | spare |
| [3:2] | prescale select |
| [1] | 32-bit width |
| [0] | one-shot |

## Requirements
- R1: After reset the load register reads 0, the count reads 0xFFFFFFFF, control reads 0x20 (disabled, free-running, 16-bit, divide by 1, interrupt enabled), the raw flag reads 0 and `irq` is low.
- R2: Control bit 0 set selects one-shot whatever bit 6 holds. With bit 0 clear, bit 6 = 1 selects periodic and bit 6 = 0 selects free-running.
- R3: In free-running mode the expiry tick sets the raw flag and loads all ones into the counting part (0xFFFFFFFF, or low half 0xFFFF). Counting then continues downward.
- R4: In periodic mode the expiry tick sets the raw flag and reloads the load value, so expiries recur every load+1 ticks.
- R5: In one-shot mode the expiry tick sets the raw flag and the count holds at zero with no further expiry. A later direct load write restarts it, with the same timing as R6.
- R6: A direct load write of L at clock edge k, while enabled at divide by 1, puts L in the count at edge k+1. The first expiry occurs at edge k+2+L. If the write of L comes while disabled and the enable write is at edge k, the same edge numbers apply.
- R7: A deferred load write changes the load register readback but not the running count. The count keeps decrementing, and the next reload uses the new value.
- R8: With bit 1 clear only bits [15:0] decrement and are tested for zero. Bits [31:16] keep their value except when a load replaces the whole word.
- R9: While enable is clear the count holds its value. After enable is set again, the count decrements from that value one edge after the enabling write.
- R10: Prescale select 00 ticks every clock, 01 every 16 clocks, 10 every 256 clocks, and 11 behaves as 10, so the count changes exactly that often.
- R11: The raw flag stays set until a write to offset 0x0C. If an expiry and a clear write fall on the same edge, the flag is set.
- R12: `irq` and the masked flag equal the raw flag ANDed with control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by counter and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 5 | Byte address for write and read; bits [4:2] select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Masked interrupt request |

## Verification
The properties assume three things about the inputs:
- `reg_wr`, `reg_addr` and `reg_wdata` are known and change only away from the rising edge.
- Reset is asserted before the first edge that is checked.
- The interrupt clear is recognised by address alone, so a clear write is never mistaken for any other access.

The stimulus drives every register access at the falling edge and keeps the address word aligned. It holds the write strobe for exactly one rising edge, so each check can name the edge on which a load, enable or clear takes effect.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        MD_FREE     = 2'd0,
        MD_PERIODIC = 2'd1,
        MD_ONESHOT  = 2'd2
    } tmr_mode_e;

    // control word, bit positions fixed by the register layout
    typedef struct packed {
        logic       en;        // [7]
        logic       periodic;  // [6]
        logic       int_en;    // [5]
        logic       spare;     // [4]
        logic [1:0] pre_sel;   // [3:2]
        logic       full_w;    // [1]
        logic       single;    // [0]
    } tmr_ctrl_t;

    localparam logic [7:0] CTRL_RST = 8'h20;

    localparam logic [2:0] W_LOAD   = 3'd0;
    localparam logic [2:0] W_VALUE  = 3'd1;
    localparam logic [2:0] W_CTRL   = 3'd2;
    localparam logic [2:0] W_CLR    = 3'd3;
    localparam logic [2:0] W_RIS    = 3'd4;
    localparam logic [2:0] W_MIS    = 3'd5;
    localparam logic [2:0] W_BGLOAD = 3'd6;

    function automatic tmr_mode_e decode_mode(input tmr_ctrl_t c);
        if (c.single)
            return MD_ONESHOT;
        else if (c.periodic)
            return MD_PERIODIC;
        return MD_FREE;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    localparam int MID_W = PRE_W / 2;

    logic [PRE_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (run)
            div_q <= div_q + 1'b1;
    end

    always_comb begin
        unique case (sel)
            2'b00:   tick = run;
            2'b01:   tick = run && (&div_q[MID_W-1:0]);
            default: tick = run && (&div_q);
        endcase
    end
endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             full_w,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output tmr_state_e       st
);
    localparam int HALF_W = CNT_W / 2;

    tmr_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_q;
    logic             pend_q;
    logic             step;
    logic             at_zero;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_IDLE;
        else
            st_q <= st_n;
    end

    // next state
    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: if (en) st_n = ST_RUN;
            ST_RUN: begin
                if (!en)
                    st_n = ST_IDLE;
                else if (expire && mode == MD_ONESHOT)
                    st_n = ST_STOP;
            end
            ST_STOP: if (load_wr) st_n = en ? ST_RUN : ST_IDLE;
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        step    = tick && en && (st_q != ST_STOP);
        at_zero = full_w ? (cnt_q == '0) : (cnt_q[HALF_W-1:0] == '0);
        expire  = step && !pend_q && at_zero;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            pend_q <= 1'b0;
        end else begin
            if (load_wr)
                pend_q <= 1'b1;
            else if (step)
                pend_q <= 1'b0;
            if (step) begin
                if (pend_q)
                    cnt_q <= load_val;
                else if (at_zero) begin
                    unique case (mode)
                        MD_FREE:     cnt_q <= full_w ? '1 : {cnt_q[CNT_W-1:HALF_W], {HALF_W{1'b1}}};
                        MD_PERIODIC: cnt_q <= load_val;
                        default:     cnt_q <= cnt_q;
                    endcase
                end else if (full_w)
                    cnt_q <= cnt_q - 1'b1;
                else
                    cnt_q <= {cnt_q[CNT_W-1:HALF_W], cnt_q[HALF_W-1:0] - 1'b1};
            end
        end
    end

    assign cnt = cnt_q;
    assign st  = st_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              expire,
    output tmr_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_wr,
    output logic              ris,
    output logic              irq,
    output logic [CNT_W-1:0]  rdata
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             bg_wr, ctrl_wr, clr_wr;
    logic             unused_lsb;
    tmr_ctrl_t        ctrl_q;
    logic [CNT_W-1:0] load_q;
    logic             ris_q;

    assign widx       = addr[ADDR_W-1:2];
    assign unused_lsb = ^addr[1:0];
    assign load_wr    = wr && (widx == IDX_W'(W_LOAD));
    assign bg_wr      = wr && (widx == IDX_W'(W_BGLOAD));
    assign ctrl_wr    = wr && (widx == IDX_W'(W_CTRL));
    assign clr_wr     = wr && (widx == IDX_W'(W_CLR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= tmr_ctrl_t'(CTRL_RST);
            load_q <= '0;
            ris_q  <= 1'b0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= tmr_ctrl_t'(wdata[7:0]);
            if (load_wr || bg_wr)
                load_q <= wdata;
            if (expire)
                ris_q <= 1'b1;
            else if (clr_wr)
                ris_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (widx)
            IDX_W'(W_LOAD), IDX_W'(W_BGLOAD): rdata = load_q;
            IDX_W'(W_VALUE): rdata = cnt;
            IDX_W'(W_CTRL):  rdata = {{(CNT_W-8){1'b0}}, ctrl_q};
            IDX_W'(W_RIS):   rdata = {{(CNT_W-1){1'b0}}, ris_q};
            IDX_W'(W_MIS):   rdata = {{(CNT_W-1){1'b0}}, ris_q & ctrl_q.int_en};
            default:         rdata = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign load_val = load_q;
    assign ris      = ris_q;
    assign irq      = ris_q & ctrl_q.int_en;
endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5,
    parameter int PRE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);
    tmr_ctrl_t        ctrl;
    tmr_mode_e        mode;
    tmr_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load_val;
    logic             load_wr;
    logic             expire;
    logic             ris;
    logic             tick;

    assign mode = decode_mode(ctrl);

    tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cnt      (cnt),
        .expire   (expire),
        .ctrl     (ctrl),
        .load_val (load_val),
        .load_wr  (load_wr),
        .ris      (ris),
        .irq      (irq),
        .rdata    (reg_rdata)
    );

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.en),
        .sel   (ctrl.pre_sel),
        .tick  (tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .en       (ctrl.en),
        .full_w   (ctrl.full_w),
        .mode     (mode),
        .load_val (load_val),
        .load_wr  (load_wr),
        .cnt      (cnt),
        .expire   (expire),
        .st       (st)
    );
endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk
    import timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input tmr_ctrl_t         ctrl,
    input tmr_state_e        st,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  load_val,
    input logic              expire,
    input logic              ris,
    input logic              irq
);
    localparam int HALF_W = CNT_W / 2;

    logic clr_seen;
    assign clr_seen = reg_wr && (reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(W_CLR));

    // R9
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |=> $stable(cnt));

    // R5
    halted_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP) |=> $stable(cnt));

    // R8
    upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.full_w |=> (cnt[CNT_W-1:HALF_W] == $past(cnt[CNT_W-1:HALF_W])) || (cnt == $past(load_val)));

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ris && !clr_seen |=> ris);

    // R11
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> ris);

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ris && ctrl.int_en));
endmodule

bind timer_channel timer_channel_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .ctrl     (ctrl),
    .st       (st),
    .cnt      (cnt),
    .load_val (load_val),
    .expire   (expire),
    .ris      (ris),
    .irq      (irq)
);

// File: tb/test_timer_channel.sv
module test_timer_channel;
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [4:0] A_LOAD  = 5'h00;
    localparam logic [4:0] A_VALUE = 5'h04;
    localparam logic [4:0] A_CTRL  = 5'h08;
    localparam logic [4:0] A_CLR   = 5'h0C;
    localparam logic [4:0] A_RIS   = 5'h10;
    localparam logic [4:0] A_MIS   = 5'h14;
    localparam logic [4:0] A_BG    = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int          n_chk = 0;
    int          n_bad = 0;
    int          n;
    logic [31:0] v;
    logic [7:0]  on;
    logic [7:0]  mode_on [4] = '{8'hA2, 8'hE2, 8'hA3, 8'hE3};

    always #2 clk = ~clk;

    timer_channel i_timer_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        #0.5;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    task automatic wait_irq(input int limit, output int cnt_edges);
        cnt_edges = -1;
        for (int i = 1; i <= limit; i++) begin
            @(posedge clk);
            #0.5;
            if (irq) begin
                cnt_edges = i;
                return;
            end
        end
    endtask

    task automatic edges(input int k);
        repeat (k) @(posedge clk);
        #0.5;
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(1);

        // R1 reset state
        rd(A_LOAD, v);  check("R1 load", v, 32'h0);
        rd(A_VALUE, v); check("R1 value", v, 32'hFFFF_FFFF);
        rd(A_CTRL, v);  check("R1 ctrl", v, 32'h20);
        rd(A_RIS, v);   check("R1 raw flag", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // mode x load sweep, 32-bit, divide by 1
        for (int m = 0; m < 4; m++) begin
            for (int L = 0; L < 6; L++) begin
                on = mode_on[m];
                wr(A_CTRL, {24'h0, on & 8'h7F});
                wr(A_LOAD, 32'(L));
                wr(A_CLR, 32'h0);
                wr(A_CTRL, {24'h0, on});
                wait_irq(50, n);
                check("R6 first expiry edge", 32'(n), 32'(L + 2));
                rd(A_VALUE, v);
                if (m == 0) begin
                    check("R3 wrap to ones", v, 32'hFFFF_FFFF);
                    wr(A_CLR, 32'h0);
                    rd(A_VALUE, v);
                    check("R3 continues after wrap", v, 32'hFFFF_FFFE);
                    check("R11 cleared", {31'b0, irq}, 32'h0);
                end else if (m == 1) begin
                    check("R4 reload value", v, 32'(L));
                    wr(A_CLR, 32'h0);
                    if (L == 0) begin
                        check("R11 expiry beats clear", {31'b0, irq}, 32'h1);
                    end else begin
                        check("R11 cleared", {31'b0, irq}, 32'h0);
                        wait_irq(50, n);
                        check("R4 period", 32'(n), 32'(L));
                    end
                end else begin
                    check(m == 3 ? "R2 one-shot over periodic bit" : "R5 halt at zero", v, 32'h0);
                    wr(A_CLR, 32'h0);
                    edges(6);
                    rd(A_VALUE, v);
                    check("R5 stays halted", v, 32'h0);
                    check("R5 no further expiry", {31'b0, irq}, 32'h0);
                    wr(A_LOAD, 32'(L + 3));
                    wait_irq(50, n);
                    check("R5 restart by load", 32'(n), 32'(L + 5));
                end
            end
        end

        // R8 narrow mode, free-running
        wr(A_CTRL, 32'h20);
        wr(A_LOAD, 32'h1234_0002);
        wr(A_CLR, 32'h0);
        wr(A_CTRL, 32'hA0);
        wait_irq(50, n);
        check("R8 narrow expiry edge", 32'(n), 32'd4);
        rd(A_VALUE, v);
        check("R8 low half wraps, upper kept", v, 32'h1234_FFFF);

        // R8 narrow periodic, upper nonzero but low half zero
        wr(A_CTRL, 32'h60);
        wr(A_LOAD, 32'h5678_0000);
        wr(A_CLR, 32'h0);
        wr(A_CTRL, 32'hE0);
        wait_irq(50, n);
        check("R8 zero test ignores upper", 32'(n), 32'd2);
        rd(A_VALUE, v);
        check("R8 narrow reload", v, 32'h5678_0000);

        // R7 deferred load
        wr(A_CTRL, 32'h62);
        wr(A_LOAD, 32'd10);
        wr(A_CLR, 32'h0);
        wr(A_CTRL, 32'hE2);
        edges(3);
        rd(A_VALUE, v);
        check("R6 count after load", v, 32'd8);
        wr(A_BG, 32'd4);
        rd(A_VALUE, v);
        check("R7 count undisturbed", v, 32'd7);
        rd(A_LOAD, v);
        check("R7 load readback", v, 32'd4);
        wait_irq(50, n);
        check("R7 old count runs out", 32'(n), 32'd8);
        rd(A_VALUE, v);
        check("R7 new reload", v, 32'd4);

        // R9 freeze and resume
        wr(A_CLR, 32'h0);
        wr(A_CTRL, 32'h62);
        rd(A_VALUE, v);
        check("R9 frozen value", v, 32'd2);
        edges(5);
        rd(A_VALUE, v);
        check("R9 held while disabled", v, 32'd2);
        wr(A_CTRL, 32'hE2);
        edges(1);
        rd(A_VALUE, v);
        check("R9 resumes from held value", v, 32'd1);

        // R10 prescaler intervals
        for (int c = 1; c < 4; c++) begin
            int          marks [3];
            int          seen;
            logic [31:0] prev;
            seen = 0;
            wr(A_CTRL, 32'h62 | 32'(c << 2));
            wr(A_LOAD, 32'd1000);
            wr(A_CLR, 32'h0);
            wr(A_CTRL, 32'hE2 | 32'(c << 2));
            rd(A_VALUE, prev);
            for (int i = 1; i <= 1200 && seen < 3; i++) begin
                edges(1);
                rd(A_VALUE, v);
                if (v != prev) begin
                    marks[seen] = i;
                    seen++;
                    prev = v;
                end
            end
            check("R10 tick interval a", 32'(marks[1] - marks[0]), c == 1 ? 32'd16 : 32'd256);
            check("R10 tick interval b", 32'(marks[2] - marks[1]), c == 1 ? 32'd16 : 32'd256);
        end

        // R12 masking, R11 stickiness
        wr(A_CTRL, 32'h42);
        wr(A_LOAD, 32'd1);
        wr(A_CLR, 32'h0);
        wr(A_CTRL, 32'hC2);
        edges(4);
        wr(A_CTRL, 32'h42);
        rd(A_RIS, v); check("R12 raw set while masked", v, 32'h1);
        rd(A_MIS, v); check("R12 masked flag low", v, 32'h0);
        check("R12 irq low when masked", {31'b0, irq}, 32'h0);
        edges(5);
        rd(A_RIS, v); check("R11 raw stays set", v, 32'h1);
        wr(A_CTRL, 32'h62);
        check("R12 irq follows enable", {31'b0, irq}, 32'h1);
        rd(A_MIS, v); check("R12 masked flag high", v, 32'h1);
        wr(A_CLR, 32'h0);
        rd(A_RIS, v); check("R11 clear write drops flag", v, 32'h0);
        check("R11 irq low after clear", {31'b0, irq}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule